// File: doc/BRIEF.md
# Answer-to-Reset Structure Parser

This block follows the variable-length structure of a smart-card answer to reset. It takes the decoded bytes that come after the initial character, one per cycle, from a character receiver. It first reads the format byte. It then walks a chain of interface-byte groups, where each chaining byte's presence nibble says which bytes of the next group will arrive. After the chain it counts off the historical bytes and, when one is required, consumes the check byte. Every output is a register that updates on the clock edge that accepts a byte.

Along the way the parser keeps the parameters a reader needs before it can negotiate:
- the clock-rate conversion code and the baud divisor code from the first group;
- the extra guard time from the first group;
- the first offered protocol;
- a bitmask of every protocol number offered.

It decides on the fly whether a check byte will follow and checks the XOR over the answer. It flags reserved parameter codes, and it flags an answer that runs past the 32-byte limit. A new answer is started by asserting reset.

Top module: `atr_parser`

## Requirements
- R1: After reset the parser behaves as if it had seen TA1 = 0x11: `fi_code` = 1 and `di_code` = 1. `egt_n`, `first_proto` and `proto_mask` are 0, and `done`, `tck_expected`, `chk_err`, `len_err` and `param_bad` are all 0.
- R2: The low nibble of the format byte (the first accepted byte) gives K, from 0 to 15. The parser consumes exactly K historical bytes after the interface bytes. When no check byte is expected, `done` rises on the edge that accepts the last historical byte, or on the last interface byte if K = 0.
- R3: Bits 4, 5, 6 and 7 of the format byte, and of each chaining byte, announce the next group's bytes in a fixed arrival order. Bit 4 announces the rate byte, bit 5 the second byte, bit 6 the guard byte and bit 7 the next chaining byte.
- R4: The rate byte of the first group loads `fi_code` from bits 7:4 and `di_code` from bits 3:0. Rate bytes in later groups do not change either output.
- R5: The guard byte of the first group loads `egt_n` from all 8 bits. Guard bytes in later groups do not change it.
- R6: Bits 3:0 of the first chaining byte load `first_proto`. Every chaining byte whose protocol number T is below 15 sets bit T of `proto_mask`, and no bit of `proto_mask` ever clears before reset.
- R7: `tck_expected` rises when any chaining byte carries T ≠ 0. In that case one check byte is consumed after the historical bytes, and `done` rises on the edge that accepts it.
- R8: `chk_err` rises with `done` when the XOR of all accepted bytes, from the format byte through the check byte, is nonzero. It stays 0 when no check byte is expected.
- R9: `param_bad` rises when any of the following is seen, and parsing carries on normally:
  - a first-group rate byte with a reserved Fi code (7, 8, 14 or 15);
  - a first-group rate byte with a reserved Di code (0, or 10 to 15);
  - a first chaining byte with T = 15.
- R10: If a 33rd byte arrives before the answer is complete, `len_err` rises and parsing halts. `done` never rises before reset, and later bytes change nothing.
- R11: Once `done` is high, further input bytes are ignored and all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also starts a new answer |
| rx_vld | input | 1 | A decoded byte is present this cycle |
| rx_byte | input | 8 | Decoded byte value |
| done | output | 1 | Answer structure complete |
| tck_expected | output | 1 | A check byte is required |
| chk_err | output | 1 | Check byte XOR failed |
| len_err | output | 1 | Answer exceeded the byte limit |
| param_bad | output | 1 | Reserved rate/divisor code or invalid first protocol |
| fi_code | output | 4 | Clock-rate conversion code |
| di_code | output | 4 | Baud divisor code |
| egt_n | output | 8 | Extra guard time count |
| first_proto | output | 4 | First offered protocol number |
| proto_mask | output | 15 | One bit per offered protocol number 0 to 14 |

## Verification
The hardest situation to reach from the ports is the length overflow. A legal-looking structure has to keep requesting bytes past the limit without completing. The stimulus gets there with a chain in which every chaining byte announces only another chaining byte with protocol 0, so that 33 bytes arrive with the parser still inside the interface section.

The sweep varies:
- the format byte's presence nibble;
- the historical count;
- the chain depth;
- later-group rate and guard bytes that must be ignored.

Its protocol numbers put T = 15 into later groups, where it must not flag an error. A separate frame puts T = 15 into the first group, where it must.

// File: rtl/atr_pkg.sv
package atr_pkg;
  localparam int NIB_W  = 4;
  localparam int NPROTO = 15;

  typedef enum logic [2:0] {
    PS_FMT  = 3'd0,
    PS_IFC  = 3'd1,
    PS_HIST = 3'd2,
    PS_TCK  = 3'd3,
    PS_END  = 3'd4,
    PS_OVF  = 3'd5
  } ph_t;

  function automatic logic fi_rsv(input logic [NIB_W-1:0] c);
    return (c == 4'd7) || (c == 4'd8) || (c >= 4'd14);
  endfunction

  function automatic logic di_rsv(input logic [NIB_W-1:0] c);
    return (c == 4'd0) || (c >= 4'd10);
  endfunction

  // phase entered once the interface section is exhausted
  function automatic ph_t after_ifc(input logic [NIB_W-1:0] k, input logic want);
    if (k != '0) return PS_HIST;
    else if (want) return PS_TCK;
    else return PS_END;
  endfunction
endpackage

// File: rtl/atr_walk.sv
module atr_walk
  import atr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_vld,
  input  logic [7:0] in_byte,
  input  logic       room,
  output ph_t        ph_q,
  output logic       need_q,
  output logic       s_go,
  output logic       s_ta1,
  output logic       s_tc1,
  output logic       s_td,
  output logic       s_td_first,
  output logic       s_tck
);
  logic [NIB_W-1:0] pend_q, pend_d, sel;
  logic [NIB_W-1:0] hist_q, hist_d;
  logic             first_q, first_d, need_d;
  ph_t              ph_d;
  logic             take, ovf, want;

  always_comb begin
    take   = in_vld && (ph_q != PS_END) && (ph_q != PS_OVF);
    ovf    = take && !room;
    s_go   = take && room;
    sel    = pend_q & (~pend_q + 4'd1);
    s_ta1  = s_go && (ph_q == PS_IFC) && sel[0] && first_q;
    s_tc1  = s_go && (ph_q == PS_IFC) && sel[2] && first_q;
    s_td   = s_go && (ph_q == PS_IFC) && sel[3];
    s_td_first = s_td && first_q;
    s_tck  = s_go && (ph_q == PS_TCK);
    want   = need_q || (s_td && (in_byte[3:0] != 4'd0));

    ph_d    = ph_q;
    pend_d  = pend_q;
    hist_d  = hist_q;
    first_d = first_q;
    need_d  = want;
    if (ovf) begin
      ph_d = PS_OVF;
    end else if (s_go) begin
      unique case (ph_q)
        PS_FMT: begin
          pend_d = in_byte[7:4];
          hist_d = in_byte[3:0];
          ph_d   = (in_byte[7:4] != '0) ? PS_IFC : after_ifc(in_byte[3:0], 1'b0);
        end
        PS_IFC: begin
          pend_d = s_td ? in_byte[7:4] : (pend_q & ~sel);
          if (s_td) first_d = 1'b0;
          if (pend_d == '0) ph_d = after_ifc(hist_q, want);
        end
        PS_HIST: begin
          hist_d = hist_q - 4'd1;
          if (hist_q == 4'd1) ph_d = need_q ? PS_TCK : PS_END;
        end
        PS_TCK:  ph_d = PS_END;
        default: ph_d = ph_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PS_FMT;
      pend_q  <= '0;
      hist_q  <= '0;
      first_q <= 1'b1;
      need_q  <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      pend_q  <= pend_d;
      hist_q  <= hist_d;
      first_q <= first_d;
      need_q  <= need_d;
    end
  end
endmodule

// File: rtl/atr_params.sv
module atr_params
  import atr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        in_byte,
  input  logic              s_ta1,
  input  logic              s_tc1,
  input  logic              s_td,
  input  logic              s_td_first,
  output logic [NIB_W-1:0]  fi_q,
  output logic [NIB_W-1:0]  di_q,
  output logic [7:0]        egt_q,
  output logic [NIB_W-1:0]  first_q,
  output logic [NPROTO-1:0] mask_q,
  output logic              bad_q
);
  logic [NIB_W-1:0]  fi_d, di_d, first_d;
  logic [7:0]        egt_d;
  logic [NPROTO-1:0] mask_d;
  logic              bad_d;

  always_comb begin
    fi_d    = fi_q;
    di_d    = di_q;
    egt_d   = egt_q;
    first_d = first_q;
    mask_d  = mask_q;
    bad_d   = bad_q;
    if (s_ta1) begin
      fi_d = in_byte[7:4];
      di_d = in_byte[3:0];
      if (fi_rsv(in_byte[7:4]) || di_rsv(in_byte[3:0])) bad_d = 1'b1;
    end
    if (s_tc1) egt_d = in_byte;
    if (s_td && (in_byte[3:0] != 4'd15)) mask_d[in_byte[3:0]] = 1'b1;
    if (s_td_first) begin
      first_d = in_byte[3:0];
      if (in_byte[3:0] == 4'd15) bad_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fi_q    <= 4'd1;
      di_q    <= 4'd1;
      egt_q   <= '0;
      first_q <= '0;
      mask_q  <= '0;
      bad_q   <= 1'b0;
    end else begin
      fi_q    <= fi_d;
      di_q    <= di_d;
      egt_q   <= egt_d;
      first_q <= first_d;
      mask_q  <= mask_d;
      bad_q   <= bad_d;
    end
  end
endmodule

// File: rtl/atr_chk.sv
module atr_chk #(
  parameter int MAX_BYTES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_byte,
  input  logic       s_go,
  input  logic       s_tck,
  output logic       room,
  output logic       err_q
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       acc_q, acc_d;
  logic             err_d;

  always_comb begin
    room  = (cnt_q != CNT_W'(MAX_BYTES));
    cnt_d = s_go ? cnt_q + 1'b1 : cnt_q;
    acc_d = s_go ? (acc_q ^ in_byte) : acc_q;
    err_d = err_q || (s_tck && ((acc_q ^ in_byte) != 8'h00));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/atr_parser.sv
module atr_parser
  import atr_pkg::*;
#(
  parameter int MAX_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_vld,
  input  logic [7:0]        rx_byte,
  output logic              done,
  output logic              tck_expected,
  output logic              chk_err,
  output logic              len_err,
  output logic              param_bad,
  output logic [3:0]        fi_code,
  output logic [3:0]        di_code,
  output logic [7:0]        egt_n,
  output logic [3:0]        first_proto,
  output logic [NPROTO-1:0] proto_mask
);
  ph_t  ph;
  logic room, s_go, s_ta1, s_tc1, s_td, s_td_first, s_tck;

  atr_walk u_walk (
    .clk(clk), .rst_n(rst_n), .in_vld(rx_vld), .in_byte(rx_byte), .room(room),
    .ph_q(ph), .need_q(tck_expected), .s_go(s_go), .s_ta1(s_ta1), .s_tc1(s_tc1),
    .s_td(s_td), .s_td_first(s_td_first), .s_tck(s_tck)
  );

  atr_params u_par (
    .clk(clk), .rst_n(rst_n), .in_byte(rx_byte), .s_ta1(s_ta1), .s_tc1(s_tc1),
    .s_td(s_td), .s_td_first(s_td_first), .fi_q(fi_code), .di_q(di_code),
    .egt_q(egt_n), .first_q(first_proto), .mask_q(proto_mask), .bad_q(param_bad)
  );

  atr_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_byte(rx_byte), .s_go(s_go), .s_tck(s_tck),
    .room(room), .err_q(chk_err)
  );

  assign done    = (ph == PS_END);
  assign len_err = (ph == PS_OVF);
endmodule

// File: rtl/atr_parser_chk.sv
module atr_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        len_err,
  input logic        chk_err,
  input logic        tck_expected,
  input logic [3:0]  fi_code,
  input logic [3:0]  di_code,
  input logic [7:0]  egt_n,
  input logic [14:0] proto_mask
);
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R11
  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> (len_err && !done)); // R10
  AST_DONE_LEN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && len_err)); // R10
  AST_CHK_WITH_TCK: assert property (@(posedge clk) disable iff (!rst_n)
    chk_err |-> (done && tck_expected)); // R8
  AST_MASK_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    ((proto_mask & $past(proto_mask)) == $past(proto_mask))); // R6
  AST_PARAM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(fi_code) && $stable(di_code) && $stable(egt_n) && $stable(proto_mask))); // R11
  AST_NONZERO_PROTO_NEEDS_TCK: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_mask[14:1] != 14'd0) |-> tck_expected); // R7
endmodule

bind atr_parser atr_parser_chk u_sva (
  .clk(clk), .rst_n(rst_n), .done(done), .len_err(len_err), .chk_err(chk_err),
  .tck_expected(tck_expected), .fi_code(fi_code), .di_code(di_code),
  .egt_n(egt_n), .proto_mask(proto_mask)
);

// File: tb/sim_atr_parser.sv
module sim_atr_parser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_vld = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        done, tck_expected, chk_err, len_err, param_bad;
  logic [3:0]  fi_code, di_code, first_proto;
  logic [7:0]  egt_n;
  logic [14:0] proto_mask;

  int nchk = 0;
  int nbad = 0;

  logic [7:0] fb [0:47];
  int         fn;

  atr_parser u0 (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte), .done(done),
    .tck_expected(tck_expected), .chk_err(chk_err), .len_err(len_err),
    .param_bad(param_bad), .fi_code(fi_code), .di_code(di_code), .egt_n(egt_n),
    .first_proto(first_proto), .proto_mask(proto_mask)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    rx_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    rx_vld  = 1'b1;
    rx_byte = b;
    @(negedge clk);
    rx_vld  = 1'b0;
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    fb[fn] = b;
    fn++;
  endtask

  function automatic logic fi_bad(input logic [3:0] c);
    return c == 4'd7 || c == 4'd8 || c == 4'd14 || c == 4'd15;
  endfunction

  function automatic logic di_bad(input logic [3:0] c);
    return c == 4'd0 || c > 4'd9;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 fi", 32'(fi_code), 32'd1);
    check("R1 di", 32'(di_code), 32'd1);
    check("R1 egt", 32'(egt_n), 32'd0);
    check("R1 mask", 32'(proto_mask), 32'd0);
    check("R1 flags", {27'd0, done, tck_expected, chk_err, len_err, param_bad}, 32'd0);

    for (int y = 0; y < 8; y++) begin
      for (int k = 0; k < 16; k++) begin
        logic [3:0]  y1, kk, p[3];
        logic [7:0]  ta, tc, x;
        int          nd;
        logic        xtra, corrupt, need, bad;
        logic [14:0] emask;
        logic [3:0]  efi, edi, efirst;
        kk = 4'(k);
        nd = k % 4;
        p[0] = (k % 3 == 0) ? 4'd0 : kk;
        p[1] = kk ^ 4'd5;
        p[2] = 4'((k * 3) & 15);
        xtra = kk[0];
        corrupt = y[0] & kk[1];
        ta = {kk, 4'(15 - k)};
        tc = 8'(k * 17);
        y1 = {(nd > 0), 3'(y)};
        fn = 0;
        push({y1, kk});
        if (y1[0]) push(ta);
        if (y1[1]) push(8'hA5);
        if (y1[2]) push(tc);
        for (int d = 0; d < nd; d++) begin
          logic [3:0] pr;
          pr = {(d < nd - 1), (d == 0) && xtra, 1'b0, (d == 0) && xtra};
          push({pr, p[d]});
          if (pr[0]) push(8'hE7);
          if (pr[2]) push(8'h3C);
        end
        for (int h = 0; h < k; h++) push(8'(h * 37 + k));
        need = 1'b0;
        emask = '0;
        for (int d = 0; d < nd; d++) begin
          if (p[d] != 4'd0) need = 1'b1;
          if (p[d] != 4'd15) emask[p[d]] = 1'b1;
        end
        if (need) begin
          x = 8'h00;
          for (int i = 0; i < fn; i++) x = x ^ fb[i];
          push(x ^ {7'd0, corrupt});
        end
        efi = y1[0] ? ta[7:4] : 4'd1;
        edi = y1[0] ? ta[3:0] : 4'd1;
        efirst = (nd > 0) ? p[0] : 4'd0;
        bad = (y1[0] && (fi_bad(ta[7:4]) || di_bad(ta[3:0]))) || (nd > 0 && p[0] == 4'd15);

        do_reset();
        for (int i = 0; i < fn - 1; i++) send(fb[i]);
        check("R2 R7 done early", 32'(done), 32'd0);
        send(fb[fn - 1]);
        check("R2 R7 done", 32'(done), 32'd1);
        check("R3 R4 fi", 32'(fi_code), 32'(efi));
        check("R3 R4 di", 32'(di_code), 32'(edi));
        check("R3 R5 egt", 32'(egt_n), y1[2] ? 32'(tc) : 32'd0);
        check("R6 first", 32'(first_proto), 32'(efirst));
        check("R6 mask", 32'(proto_mask), 32'(emask));
        check("R7 tck_expected", 32'(tck_expected), 32'(need));
        check("R8 chk_err", 32'(chk_err), 32'(need && corrupt));
        check("R9 param_bad", 32'(param_bad), 32'(bad));
        check("R10 len_err", 32'(len_err), 32'd0);
        // R11 trailing byte ignored
        send(8'h9F);
        check("R11 hold done", 32'(done), 32'd1);
        check("R11 hold fi", 32'(fi_code), 32'(efi));
        check("R11 hold mask", 32'(proto_mask), 32'(emask));
      end
    end

    // R9 T=15 in first chaining byte, parsing continues; default rate stays valid
    do_reset();
    send(8'h81);          // chaining present, one historical byte
    send(8'h0F);          // first chaining byte, T=15
    send(8'h42);          // historical byte
    check("R9 bad first T15", 32'(param_bad), 32'd1);
    check("R9 first_proto", 32'(first_proto), 32'd15);
    check("R9 still expects check byte", 32'(done), 32'd0);
    send(8'h81 ^ 8'h0F ^ 8'h42);
    check("R9 R8 done good xor", {30'd0, done, chk_err}, 32'd2);

    // R10 overflow: 32 chaining bytes with nothing else, then a 33rd
    do_reset();
    send(8'h80);
    for (int i = 0; i < 31; i++) send(8'h80);
    check("R10 no error at 32", 32'(len_err), 32'd0);
    send(8'h80);
    check("R10 len_err at 33", 32'(len_err), 32'd1);
    check("R10 no done", 32'(done), 32'd0);
    send(8'h00);
    check("R10 halted", {30'd0, len_err, done}, 32'd2);

    // R2 exact 32-byte legal answer: format byte K=15, groups filling to 32
    do_reset();
    send(8'h8F);
    for (int i = 0; i < 15; i++) send(8'h80);
    send(8'h00);
    for (int i = 0; i < 15; i++) send(8'h11);
    check("R2 R10 32-byte answer done", {30'd0, done, len_err}, 32'd2);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule